// File: doc/BRIEF.md
# Iterative Integer Divide and Remainder Unit

This block computes integer quotients and remainders for a 64-bit scalar pipeline. It covers signed and unsigned division and remainder at full register width. It also covers word forms that work on the low half of each operand and return a sign-extended half-width result. A request carries a 3-bit operation code and two operands. It is taken in while the unit is idle. The answer comes back with a single-cycle done strobe.

Ordinary operations run a radix-2 restoring loop on operand magnitudes, one quotient bit per cycle, and then apply the signs. Division by zero and signed overflow never raise an exception. Both are detected while the request is taken in and answered from a bypass path without entering the loop. The datapath width is the parameter `XLEN`, and the word forms use `XLEN/2` bits.

Top module: `div_unit`

## Requirements
- R1: The operation code `req_op` has three fields. Bit 2 selects the word form, bit 1 selects remainder (0 gives the quotient), and bit 0 selects unsigned (0 gives signed). A request is taken in on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so a request presented while an operation is in progress has no effect on that operation's result.
- R2: The quotient is rounded toward zero, for both signed and unsigned operands.
- R3: A nonzero-divisor remainder satisfies dividend = quotient × divisor + remainder. It carries the sign of the dividend.
- R4: When the extended divisor is zero, the quotient result has every bit set.
- R5: When the extended divisor is zero, the remainder result is the extended dividend, passed through the word-form result rule when a word form is used.
- R6: In the signed overflow case the quotient result equals the dividend. Signed overflow means the dividend is the most negative value of the operation width and the divisor is all ones.
- R7: In the signed overflow case the remainder result is zero.
- R8: In the word forms, only the low `XLEN/2` bits of each operand are used. The signed word forms sign-extend those bits and the unsigned word forms zero-extend them.
- R9: Every word-form result is sign-extended from bit `XLEN/2-1` to the full width.
- R10: Division by zero and signed overflow produce `rsp_done` in the cycle right after the accepting edge.
- R11: Any other operation produces `rsp_done` XLEN+1 cycles after the accepting edge, or XLEN/2+1 cycles for a word form.
- R12: `rsp_done` stays high for exactly one cycle, and `rsp_result` reads zero whenever `rsp_done` is low.
- R13: After reset the unit is idle, with `req_ready` high, `rsp_done` low and `rsp_result` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit is idle and will take a request |
| req_op | input | 3 | Operation: bit 2 word, bit 1 remainder, bit 0 unsigned |
| req_a | input | XLEN | Dividend |
| req_b | input | XLEN | Divisor |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_result | output | XLEN | Quotient or remainder, valid with `rsp_done` |

## Verification
The hardest cases to reach are the two signed overflow corners, at both widths. Each one needs an exact dividend bit pattern paired with an all-ones divisor. For the word forms this pattern sits in the low half only, and the upper operand bits must not matter. The bench builds the unit at 8 bits, so the word width is 4 bits. It sweeps every dividend value against a divisor set that includes zero, all ones, a value whose low half is zero, and ordinary values. This hits both overflow corners and the zero-divisor cases for all eight operations, with the upper operand bits cycling through every pattern. Expected results come from integer arithmetic in the bench, which also measures the latency of every operation.

// File: rtl/divu_pkg.sv
package divu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_t;

    // bit 2: word form, bit 1: remainder, bit 0: unsigned
    typedef struct packed {
        logic word;
        logic rem;
        logic uns;
    } div_op_t;

    function automatic div_op_t decode_op(input logic [2:0] code);
        return div_op_t'(code);
    endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep
    import divu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  div_op_t           op_i,
    input  logic [XLEN-1:0]   a_i,
    input  logic [XLEN-1:0]   b_i,
    output logic [XLEN-1:0]   ext_a_o,
    output logic [XLEN-1:0]   mag_a_o,
    output logic [XLEN-1:0]   mag_b_o,
    output logic              neg_a_o,
    output logic              neg_b_o,
    output logic              zero_o,
    output logic              ovf_o
);
    localparam int W = XLEN / 2;

    logic [XLEN-1:0] ea, eb;
    logic            ovf_full, ovf_word;

    always_comb begin
        if (op_i.word) begin
            ea = op_i.uns ? {{W{1'b0}}, a_i[W-1:0]} : {{W{a_i[W-1]}}, a_i[W-1:0]};
            eb = op_i.uns ? {{W{1'b0}}, b_i[W-1:0]} : {{W{b_i[W-1]}}, b_i[W-1:0]};
        end else begin
            ea = a_i;
            eb = b_i;
        end
        neg_a_o  = !op_i.uns && ea[XLEN-1];
        neg_b_o  = !op_i.uns && eb[XLEN-1];
        mag_a_o  = neg_a_o ? (~ea + 1'b1) : ea;
        mag_b_o  = neg_b_o ? (~eb + 1'b1) : eb;
        zero_o   = (eb == '0);
        ovf_full = (a_i == {1'b1, {(XLEN-1){1'b0}}}) && (&b_i);
        ovf_word = (a_i[W-1:0] == {1'b1, {(W-1){1'b0}}}) && (&b_i[W-1:0]);
        ovf_o    = !op_i.uns && !zero_o && (op_i.word ? ovf_word : ovf_full);
        ext_a_o  = ea;
    end

endmodule

// File: rtl/div_core.sv
module div_core #(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic            step_i,
    input  logic            word_i,
    input  logic [XLEN-1:0] mag_a_i,
    input  logic [XLEN-1:0] mag_b_i,
    output logic [XLEN-1:0] quo_o,
    output logic [XLEN-1:0] rem_o
);
    localparam int W = XLEN / 2;

    logic [XLEN-1:0] quo_q, rem_q, dvs_q;
    logic [XLEN:0]   shifted, trial;
    logic            fits;

    always_comb begin
        shifted = {rem_q, quo_q[XLEN-1]};
        fits    = (shifted >= {1'b0, dvs_q});
        trial   = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            // word magnitudes are pre-aligned so the loop runs W steps
            quo_q <= word_i ? (mag_a_i << W) : mag_a_i;
            rem_q <= '0;
            dvs_q <= mag_b_i;
        end else if (step_i) begin
            quo_q <= {quo_q[XLEN-2:0], fits};
            rem_q <= fits ? trial[XLEN-1:0] : shifted[XLEN-1:0];
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

endmodule

// File: rtl/div_fix.sv
module div_fix #(
    parameter int XLEN = 64
) (
    input  logic            word_i,
    input  logic            rem_sel_i,
    input  logic            neg_q_i,
    input  logic            neg_r_i,
    input  logic            bypass_i,
    input  logic [XLEN-1:0] bypass_val_i,
    input  logic [XLEN-1:0] quo_i,
    input  logic [XLEN-1:0] rem_i,
    output logic [XLEN-1:0] res_o
);
    localparam int W = XLEN / 2;

    logic [XLEN-1:0] q_s, r_s, raw;

    always_comb begin
        q_s   = neg_q_i ? (~quo_i + 1'b1) : quo_i;
        r_s   = neg_r_i ? (~rem_i + 1'b1) : rem_i;
        raw   = bypass_i ? bypass_val_i : (rem_sel_i ? r_s : q_s);
        res_o = word_i ? {{W{raw[W-1]}}, raw[W-1:0]} : raw;
    end

endmodule

// File: rtl/div_unit.sv
module div_unit
    import divu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2:0]      req_op,
    input  logic [XLEN-1:0] req_a,
    input  logic [XLEN-1:0] req_b,
    output logic            rsp_done,
    output logic [XLEN-1:0] rsp_result
);
    localparam int W    = XLEN / 2;
    localparam int CW   = $clog2(XLEN + 1);
    localparam logic [CW-1:0] LAST_FULL = CW'(XLEN - 1);
    localparam logic [CW-1:0] LAST_WORD = CW'(W - 1);

    div_state_t      state_q;
    logic [CW-1:0]   cnt_q;
    div_op_t         op_in;
    logic            word_q, rem_q, neg_q_q, neg_r_q, bypass_q;
    logic [XLEN-1:0] bypass_val_q;

    logic [XLEN-1:0] ext_a, mag_a, mag_b, quo, rem, fix_res, bypass_val_d;
    logic            neg_a, neg_b, zero_b, ovf;
    logic            accept, step;

    assign op_in     = decode_op(req_op);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign step      = (state_q == ST_RUN);

    div_prep #(.XLEN(XLEN)) u_prep (
        .op_i    (op_in),
        .a_i     (req_a),
        .b_i     (req_b),
        .ext_a_o (ext_a),
        .mag_a_o (mag_a),
        .mag_b_o (mag_b),
        .neg_a_o (neg_a),
        .neg_b_o (neg_b),
        .zero_o  (zero_b),
        .ovf_o   (ovf)
    );

    div_core #(.XLEN(XLEN)) u_core (
        .clk     (clk),
        .rst     (rst),
        .load_i  (accept),
        .step_i  (step),
        .word_i  (op_in.word),
        .mag_a_i (mag_a),
        .mag_b_i (mag_b),
        .quo_o   (quo),
        .rem_o   (rem)
    );

    always_comb begin
        if (zero_b)
            bypass_val_d = op_in.rem ? ext_a : '1;
        else
            bypass_val_d = op_in.rem ? '0 : ext_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            cnt_q        <= '0;
            word_q       <= 1'b0;
            rem_q        <= 1'b0;
            neg_q_q      <= 1'b0;
            neg_r_q      <= 1'b0;
            bypass_q     <= 1'b0;
            bypass_val_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    word_q       <= op_in.word;
                    rem_q        <= op_in.rem;
                    neg_q_q      <= neg_a ^ neg_b;
                    neg_r_q      <= neg_a;
                    bypass_q     <= zero_b || ovf;
                    bypass_val_q <= bypass_val_d;
                    cnt_q        <= op_in.word ? LAST_WORD : LAST_FULL;
                    state_q      <= (zero_b || ovf) ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    if (cnt_q == '0)
                        state_q <= ST_FIN;
                    else
                        cnt_q <= cnt_q - 1'b1;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    div_fix #(.XLEN(XLEN)) u_fix (
        .word_i       (word_q),
        .rem_sel_i    (rem_q),
        .neg_q_i      (neg_q_q),
        .neg_r_i      (neg_r_q),
        .bypass_i     (bypass_q),
        .bypass_val_i (bypass_val_q),
        .quo_i        (quo),
        .rem_i        (rem),
        .res_o        (fix_res)
    );

    assign rsp_done   = (state_q == ST_FIN);
    assign rsp_result = rsp_done ? fix_res : '0;

endmodule

// File: rtl/div_unit_checker.sv
module div_unit_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [2:0]      req_op,
    input logic [XLEN-1:0] req_a,
    input logic [XLEN-1:0] req_b,
    input logic            rsp_done,
    input logic [XLEN-1:0] rsp_result
);
    localparam int W = XLEN / 2;

    logic        acc, zb, ovf_in, pend, pend_spec;
    logic [15:0] lat, exp_lat;

    always_comb begin
        acc    = req_valid && req_ready;
        zb     = req_op[2] ? (req_b[W-1:0] == '0) : (req_b == '0);
        ovf_in = !req_op[0] && !zb &&
                 (req_op[2] ? ((req_a[W-1:0] == {1'b1, {(W-1){1'b0}}}) && (&req_b[W-1:0]))
                            : ((req_a == {1'b1, {(XLEN-1){1'b0}}}) && (&req_b)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_spec <= 1'b0;
            lat       <= '0;
            exp_lat   <= '0;
        end else if (acc) begin
            pend      <= 1'b1;
            pend_spec <= zb || ovf_in;
            lat       <= 16'd1;
            exp_lat   <= req_op[2] ? 16'(W + 1) : 16'(XLEN + 1);
        end else if (pend) begin
            lat <= lat + 1'b1;
            if (rsp_done) pend <= 1'b0;
        end
    end

    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
        pend |-> !req_ready);
    assert_zero_quotient_R4: assert property (@(posedge clk) disable iff (rst)
        (acc && zb && !req_op[1]) |=> (rsp_done && rsp_result == '1));
    assert_ovf_remainder_R7: assert property (@(posedge clk) disable iff (rst)
        (acc && ovf_in && req_op[1]) |=> (rsp_done && rsp_result == '0));
    assert_bypass_latency_R10: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && pend_spec) |-> (pend && lat == 16'd1));
    assert_loop_latency_R11: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && !pend_spec) |-> (pend && lat == exp_lat));
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    assert_quiet_result_R12: assert property (@(posedge clk) disable iff (rst)
        !rsp_done |-> (rsp_result == '0));

endmodule

bind div_unit div_unit_checker #(.XLEN(XLEN)) u_div_unit_checker (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_a      (req_a),
    .req_b      (req_b),
    .rsp_done   (rsp_done),
    .rsp_result (rsp_result)
);

// File: tb/div_unit_bench.sv
`timescale 1ns/1ps
module div_unit_bench;
    localparam int BX = 8;
    localparam int BW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [BX-1:0] req_a = '0;
    logic [BX-1:0] req_b = '0;
    logic          rsp_done;
    logic [BX-1:0] rsp_result;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    div_unit #(.XLEN(BX)) u_div_unit (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_op     (req_op),
        .req_a      (req_a),
        .req_b      (req_b),
        .rsp_done   (rsp_done),
        .rsp_result (rsp_result)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // operand value as the operation sees it
    function automatic int opnd(input logic [2:0] op, input logic [BX-1:0] v);
        int u;
        if (op[2]) begin
            u = int'(v[BW-1:0]);
            return (!op[0] && v[BW-1]) ? u - (1 << BW) : u;
        end
        u = int'(v);
        return (!op[0] && v[BX-1]) ? u - (1 << BX) : u;
    endfunction

    function automatic logic [BX-1:0] model(input logic [2:0] op,
                                            input logic [BX-1:0] a, input logic [BX-1:0] b);
        int x, y, q, r, res;
        logic [BX-1:0] v;
        x = opnd(op, a);
        y = opnd(op, b);
        if (y == 0) begin
            q = -1;
            r = x;
        end else begin
            q = x / y;
            r = x % y;
        end
        res = op[1] ? r : q;
        v = res[BX-1:0];
        if (op[2]) v = {{(BX-BW){v[BW-1]}}, v[BW-1:0]};
        return v;
    endfunction

    function automatic logic is_bypass(input logic [2:0] op,
                                       input logic [BX-1:0] a, input logic [BX-1:0] b);
        int x, y, lo;
        x  = opnd(op, a);
        y  = opnd(op, b);
        lo = op[2] ? -(1 << (BW-1)) : -(1 << (BX-1));
        return (y == 0) || (!op[0] && x == lo && y == -1);
    endfunction

    function automatic string tag_of(input logic [2:0] op,
                                     input logic [BX-1:0] a, input logic [BX-1:0] b);
        int y;
        y = opnd(op, b);
        if (y == 0) return op[1] ? "R5" : "R4";
        if (is_bypass(op, a, b)) return op[1] ? "R7" : "R6";
        if (op[2]) return "R8 R9";
        return op[1] ? "R3" : "R2";
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [BX-1:0] a, input logic [BX-1:0] b);
        int cyc;
        logic [BX-1:0] exp_v;
        exp_v = model(op, a, b);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_a     = a;
        req_b     = b;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!rsp_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        check(tag_of(op, a, b), int'(rsp_result), int'(exp_v));
        if (is_bypass(op, a, b))
            check("R10 latency", cyc, 1);
        else
            check("R11 latency", cyc, (op[2] ? BW : BX) + 1);
        @(negedge clk);
        check("R12 done width", int'(rsp_done), 0);
        check("R12 idle result", int'(rsp_result), 0);
    endtask

    initial begin
        #700000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [BX-1:0] bset [6];
        logic [BX-1:0] exp_first;
        int cyc;
        bset[0] = 8'h00; bset[1] = 8'h01; bset[2] = 8'hFF;
        bset[3] = 8'h80; bset[4] = 8'h03; bset[5] = 8'h7B;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: reset state
        check("R13 ready", int'(req_ready), 1);
        check("R13 done", int'(rsp_done), 0);
        check("R13 result", int'(rsp_result), 0);

        // R1: busy unit ignores a second request
        exp_first = model(3'b000, 8'hC5, 8'h07);
        req_valid = 1'b1; req_op = 3'b000; req_a = 8'hC5; req_b = 8'h07;
        @(negedge clk);
        check("R1 busy ready", int'(req_ready), 0);
        req_op = 3'b011; req_a = 8'h11; req_b = 8'h00;
        cyc = 1;
        while (!rsp_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check("R1 ignored request", int'(rsp_result), int'(exp_first));
        check("R11 latency", cyc, BX + 1);
        @(negedge clk);
        check("R1 back to idle", int'(req_ready), 1);

        // sweep every operation, every dividend, divisor corner set
        for (int op = 0; op < 8; op++) begin
            for (int ai = 0; ai < 256; ai++) begin
                for (int bi = 0; bi < 6; bi++) begin
                    run_op(3'(op), 8'(ai), bset[bi]);
                end
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule